// File: doc/BRIEF.md
# Microcoded Accumulator Processor Core

This block is a small processor whose every control signal comes from a 128-word by 20-bit microcode store inside the module. It has four architectural registers: an 11-bit address register, an 11-bit program counter, a 16-bit data register and a 16-bit accumulator. These registers exchange values through multiplexers, not through a shared bus. The processor runs programs held in an external word-addressed memory. That memory is written synchronously and returns read data for the address on the memory address port in the same cycle.

Each microword holds three 3-bit operation selectors, a 2-bit condition select, a 2-bit next-address mode and a 7-bit target. Each selector goes to its own 3-to-8 decoder. A given code value means a different register transfer depending on which selector holds it. The microsequencer keeps a microaddress register and a one-deep return register. Each cycle it either steps, jumps, calls, returns, or maps the instruction opcode to the start of that opcode's routine. Every instruction first runs a common three-cycle fetch. It then runs its own routine, resolves indirection through a shared subroutine when needed, and jumps back to fetch.

Top module: `upc_core`

## Requirements
- R1: While rst_n is low, acc_o and pc_o are 0, mem_we is 0, and fetch_o is 1, because the microaddress rests at the first fetch word.
- R2: An instruction word has the indirect flag in bit 15, the opcode in bits 14..11 and the address in bits 10..0. Opcode 0000 adds the memory word at the effective address to the accumulator, wrapping modulo 2^16.
- R3: Opcode 0001 loads the program counter with the effective address when accumulator bit 15 is 1. Otherwise the program counter keeps its value from fetch.
- R4: Opcode 0010 writes the accumulator to the memory word at the effective address.
- R5: Opcode 0011 swaps the accumulator and the memory word at the effective address. Both transfers happen in one cycle.
- R6: When bit 15 of the instruction is 1, the effective address is bits 10..0 of the memory word at the instruction's address field. Resolving it adds exactly two cycles.
- R7: fetch_o is 1 for exactly the first cycle of each instruction. An instruction lasts 6 cycles for add, 6 for a taken branch, 5 for a branch not taken, 6 for store and 7 for exchange, plus the indirect cycles of R6.
- R8: mem_we is high for exactly one cycle per store and per exchange, and never otherwise.
- R9: Each fetch adds one to the program counter, modulo 2^11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | ADDR_W | Memory word address (address register) |
| mem_wdata | output | DATA_W | Memory write data (data register) |
| mem_we | output | 1 | Memory write strobe for the current cycle |
| mem_rdata | input | DATA_W | Memory read data for mem_addr, same cycle |
| acc_o | output | DATA_W | Accumulator value |
| pc_o | output | ADDR_W | Program counter value |
| fetch_o | output | 1 | High in the first cycle of each instruction |

## Verification
The test program uses each opcode in its direct form and, except for a branch that is not taken, in its indirect form as well. This separates a wrong effective address from a wrong operation. Exchanges run back to back on the same word, so a swap that is not simultaneous leaves a different memory value. The branch is tried once with a positive accumulator and once with a negative one, and the program then settles in a self-loop. A behavioural instruction model predicts the length of every instruction, so a sequencing fault shows up as a fetch pulse in the wrong cycle. At the end, the memory words written by the processor are compared with the model's memory.

// File: rtl/upc_pkg.sv
package upc_pkg;

   localparam int UA_W  = 7;
   localparam int SEL_W = 3;

   typedef enum logic [1:0] {
      CD_U = 2'd0,   // always true
      CD_I = 2'd1,   // indirect flag of the data register
      CD_S = 2'd2,   // accumulator sign
      CD_Z = 2'd3    // accumulator zero
   } cond_e;

   typedef enum logic [1:0] {
      BR_JMP  = 2'd0,
      BR_CALL = 2'd1,
      BR_RET  = 2'd2,
      BR_MAP  = 2'd3
   } br_e;

   typedef struct packed {
      logic [SEL_W-1:0] f1;
      logic [SEL_W-1:0] f2;
      logic [SEL_W-1:0] f3;
      cond_e            cd;
      br_e              br;
      logic [UA_W-1:0]  ad;
   } uword_t;

   // first selector
   localparam logic [2:0] S1_ADD   = 3'd1;
   localparam logic [2:0] S1_CLR   = 3'd2;
   localparam logic [2:0] S1_INC   = 3'd3;
   localparam logic [2:0] S1_D2A   = 3'd4;
   localparam logic [2:0] S1_D2AR  = 3'd5;
   localparam logic [2:0] S1_P2AR  = 3'd6;
   localparam logic [2:0] S1_WR    = 3'd7;
   // second selector
   localparam logic [2:0] S2_SUB   = 3'd1;
   localparam logic [2:0] S2_OR    = 3'd2;
   localparam logic [2:0] S2_AND   = 3'd3;
   localparam logic [2:0] S2_RD    = 3'd4;
   localparam logic [2:0] S2_A2D   = 3'd5;
   localparam logic [2:0] S2_INCD  = 3'd6;
   localparam logic [2:0] S2_P2D   = 3'd7;
   // third selector
   localparam logic [2:0] S3_XOR   = 3'd1;
   localparam logic [2:0] S3_COM   = 3'd2;
   localparam logic [2:0] S3_SHL   = 3'd3;
   localparam logic [2:0] S3_SHR   = 3'd4;
   localparam logic [2:0] S3_INCP  = 3'd5;
   localparam logic [2:0] S3_AR2P  = 3'd6;

   // microaddresses the sequence depends on
   localparam logic [UA_W-1:0] UA_FETCH   = 7'd64;
   localparam logic [UA_W-1:0] UA_DECODE  = 7'd66;
   localparam logic [UA_W-1:0] UA_INDIR   = 7'd67;
   localparam logic [UA_W-1:0] UA_IND_RET = 7'd68;
   localparam logic [UA_W-1:0] UA_ADD_EXE = 7'd2;
   localparam logic [UA_W-1:0] UA_XCH_SWP = 7'd14;

   function automatic uword_t mk_uw(input logic [2:0] a, input logic [2:0] b,
                                    input logic [2:0] c, input cond_e cd,
                                    input br_e br, input logic [UA_W-1:0] ad);
      uword_t w;
      w.f1 = a;
      w.f2 = b;
      w.f3 = c;
      w.cd = cd;
      w.br = br;
      w.ad = ad;
      return w;
   endfunction

endpackage

// File: rtl/upc_ucode_rom.sv
module upc_ucode_rom
   import upc_pkg::*;
(
   input  logic [UA_W-1:0] addr,
   output uword_t          word
);

   function automatic uword_t rom_word(input logic [UA_W-1:0] a);
      case (a)
         // add routine
         7'd0:  return mk_uw(3'd0,    3'd0,    3'd0,    CD_I, BR_CALL, UA_INDIR);
         7'd1:  return mk_uw(3'd0,    S2_RD,   3'd0,    CD_U, BR_JMP,  7'd2);
         7'd2:  return mk_uw(S1_ADD,  3'd0,    3'd0,    CD_U, BR_JMP,  UA_FETCH);
         // branch routine
         7'd4:  return mk_uw(3'd0,    3'd0,    3'd0,    CD_S, BR_JMP,  7'd6);
         7'd5:  return mk_uw(3'd0,    3'd0,    3'd0,    CD_U, BR_JMP,  UA_FETCH);
         7'd6:  return mk_uw(3'd0,    3'd0,    3'd0,    CD_I, BR_CALL, UA_INDIR);
         7'd7:  return mk_uw(3'd0,    3'd0,    S3_AR2P, CD_U, BR_JMP,  UA_FETCH);
         // store routine
         7'd8:  return mk_uw(3'd0,    3'd0,    3'd0,    CD_I, BR_CALL, UA_INDIR);
         7'd9:  return mk_uw(3'd0,    S2_A2D,  3'd0,    CD_U, BR_JMP,  7'd10);
         7'd10: return mk_uw(S1_WR,   3'd0,    3'd0,    CD_U, BR_JMP,  UA_FETCH);
         // exchange routine
         7'd12: return mk_uw(3'd0,    3'd0,    3'd0,    CD_I, BR_CALL, UA_INDIR);
         7'd13: return mk_uw(3'd0,    S2_RD,   3'd0,    CD_U, BR_JMP,  7'd14);
         7'd14: return mk_uw(S1_D2A,  S2_A2D,  3'd0,    CD_U, BR_JMP,  7'd15);
         7'd15: return mk_uw(S1_WR,   3'd0,    3'd0,    CD_U, BR_JMP,  UA_FETCH);
         // common fetch and decode
         7'd64: return mk_uw(S1_P2AR, 3'd0,    3'd0,    CD_U, BR_JMP,  7'd65);
         7'd65: return mk_uw(3'd0,    S2_RD,   S3_INCP, CD_U, BR_JMP,  7'd66);
         7'd66: return mk_uw(S1_D2AR, 3'd0,    3'd0,    CD_U, BR_MAP,  7'd0);
         // indirect resolution subroutine
         7'd67: return mk_uw(3'd0,    S2_RD,   3'd0,    CD_U, BR_JMP,  7'd68);
         7'd68: return mk_uw(S1_D2AR, 3'd0,    3'd0,    CD_U, BR_RET,  7'd0);
         default: return mk_uw(3'd0,  3'd0,    3'd0,    CD_U, BR_JMP,  UA_FETCH);
      endcase
   endfunction

   always_comb word = rom_word(addr);

endmodule

// File: rtl/upc_sel_dec.sv
module upc_sel_dec #(
   parameter int IN_W = 3,
   localparam int OUT_N = 1 << IN_W
) (
   input  logic [IN_W-1:0]  code,
   output logic [OUT_N-1:0] hot
);

   always_comb begin
      hot       = '0;
      hot[code] = 1'b1;
   end

endmodule

// File: rtl/upc_seq.sv
module upc_seq
   import upc_pkg::*;
#(
   parameter int OPC_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  uword_t           uw,
   input  logic             c_ind,
   input  logic             c_sign,
   input  logic             c_zero,
   input  logic [OPC_W-1:0] opcode,
   output logic [UA_W-1:0]  car,
   output logic [UA_W-1:0]  sbr
);

   logic            taken;
   logic [UA_W-1:0] car_inc;
   logic [UA_W-1:0] map_ua;

   always_comb begin
      unique case (uw.cd)
         CD_U:    taken = 1'b1;
         CD_I:    taken = c_ind;
         CD_S:    taken = c_sign;
         default: taken = c_zero;
      endcase
   end

   assign car_inc = car + 1'b1;
   assign map_ua  = UA_W'({opcode, 2'b00});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         car <= UA_FETCH;
         sbr <= '0;
      end else begin
         unique case (uw.br)
            BR_JMP:  car <= taken ? uw.ad : car_inc;
            BR_CALL: begin
               if (taken) begin
                  car <= uw.ad;
                  sbr <= car_inc;
               end else begin
                  car <= car_inc;
               end
            end
            BR_RET:  car <= sbr;
            default: car <= map_ua;
         endcase
      end
   end

endmodule

// File: rtl/upc_dp.sv
module upc_dp #(
   parameter int DATA_W    = 16,
   parameter int ADDR_W    = 11,
   parameter bit SHR_ARITH = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [7:0]        h1,
   input  logic [7:0]        h2,
   input  logic [7:0]        h3,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [ADDR_W-1:0] ar_q,
   output logic [ADDR_W-1:0] pc_q,
   output logic [DATA_W-1:0] dr_q,
   output logic [DATA_W-1:0] ac_q
);

   logic [DATA_W-1:0] ac_nxt;
   logic [DATA_W-1:0] shr_val;

   generate
      if (SHR_ARITH) begin : g_shr_arith
         assign shr_val = {ac_q[DATA_W-1], ac_q[DATA_W-1:1]};
      end else begin : g_shr_logic
         assign shr_val = {1'b0, ac_q[DATA_W-1:1]};
      end
   endgenerate

   // F1 wins over F2, F2 over F3 when several touch the accumulator
   always_comb begin
      ac_nxt = ac_q;
      if (h3[1]) ac_nxt = ac_q ^ dr_q;
      if (h3[2]) ac_nxt = ~ac_q;
      if (h3[3]) ac_nxt = ac_q << 1;
      if (h3[4]) ac_nxt = shr_val;
      if (h2[1]) ac_nxt = ac_q - dr_q;
      if (h2[2]) ac_nxt = ac_q | dr_q;
      if (h2[3]) ac_nxt = ac_q & dr_q;
      if (h1[1]) ac_nxt = ac_q + dr_q;
      if (h1[2]) ac_nxt = '0;
      if (h1[3]) ac_nxt = ac_q + 1'b1;
      if (h1[4]) ac_nxt = dr_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ar_q <= '0;
         pc_q <= '0;
         dr_q <= '0;
         ac_q <= '0;
      end else begin
         ac_q <= ac_nxt;

         if (h1[5])      ar_q <= dr_q[ADDR_W-1:0];
         else if (h1[6]) ar_q <= pc_q;

         if (h3[6])      pc_q <= ar_q;
         else if (h3[5]) pc_q <= pc_q + 1'b1;

         if (h2[4])      dr_q <= mem_rdata;
         else if (h2[5]) dr_q <= ac_q;
         else if (h2[6]) dr_q <= dr_q + 1'b1;
         else if (h2[7]) dr_q[ADDR_W-1:0] <= pc_q;
      end
   end

endmodule

// File: rtl/upc_core.sv
module upc_core
   import upc_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int ADDR_W    = 11,
   parameter int OPC_W     = 4,
   parameter bit SHR_ARITH = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_we,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [DATA_W-1:0] acc_o,
   output logic [ADDR_W-1:0] pc_o,
   output logic              fetch_o
);

   localparam int N_SEL  = 3;
   localparam int OPC_LO = DATA_W - 1 - OPC_W;

   generate
      if (DATA_W != 1 + OPC_W + ADDR_W) begin : g_bad_format
         $error("instruction word must be flag + opcode + address");
      end
      if (OPC_W + 3 != UA_W) begin : g_bad_map
         $error("opcode width must leave four words per routine");
      end
      if (SEL_W != 3) begin : g_bad_sel
         $error("selectors must be three bits wide");
      end
   endgenerate

   uword_t            uw;
   logic [UA_W-1:0]   car_q;
   logic [UA_W-1:0]   sbr_q;
   logic [SEL_W-1:0]  sel   [N_SEL];
   logic [7:0]        hot   [N_SEL];
   logic [ADDR_W-1:0] ar_q;
   logic [ADDR_W-1:0] pc_q;
   logic [DATA_W-1:0] dr_q;
   logic [DATA_W-1:0] ac_q;

   upc_ucode_rom u_rom (
      .addr (car_q),
      .word (uw)
   );

   assign sel[0] = uw.f1;
   assign sel[1] = uw.f2;
   assign sel[2] = uw.f3;

   generate
      for (genvar g = 0; g < N_SEL; g++) begin : g_dec
         upc_sel_dec #(.IN_W(SEL_W)) u_dec (
            .code (sel[g]),
            .hot  (hot[g])
         );
      end
   endgenerate

   upc_seq #(.OPC_W(OPC_W)) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .uw     (uw),
      .c_ind  (dr_q[DATA_W-1]),
      .c_sign (ac_q[DATA_W-1]),
      .c_zero (ac_q == '0),
      .opcode (dr_q[OPC_LO +: OPC_W]),
      .car    (car_q),
      .sbr    (sbr_q)
   );

   upc_dp #(
      .DATA_W    (DATA_W),
      .ADDR_W    (ADDR_W),
      .SHR_ARITH (SHR_ARITH)
   ) u_dp (
      .clk       (clk),
      .rst_n     (rst_n),
      .h1        (hot[0]),
      .h2        (hot[1]),
      .h3        (hot[2]),
      .mem_rdata (mem_rdata),
      .ar_q      (ar_q),
      .pc_q      (pc_q),
      .dr_q      (dr_q),
      .ac_q      (ac_q)
   );

   assign mem_addr  = ar_q;
   assign mem_wdata = dr_q;
   assign mem_we    = hot[0][7];
   assign acc_o     = ac_q;
   assign pc_o      = pc_q;
   assign fetch_o   = (car_q == UA_FETCH);

endmodule

// File: rtl/upc_core_sva.sv
module upc_core_sva
   import upc_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 11
) (
   input logic              clk,
   input logic              rst_n,
   input logic [UA_W-1:0]   car,
   input logic [UA_W-1:0]   sbr,
   input logic [ADDR_W-1:0] pc,
   input logic [DATA_W-1:0] ac,
   input logic [DATA_W-1:0] dr,
   input logic              mem_we
);

   // R7: fetch proceeds in order
   a_r7_fetch_order: assert property (@(posedge clk) disable iff (!rst_n)
      (car == UA_FETCH) |=> (car == UA_FETCH + 7'd1));

   // R7: opcode mapping lands on a routine start below fetch
   a_r7_map_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      (car == UA_DECODE) |=> (car[1:0] == 2'b00 && car < UA_FETCH));

   // R9: program counter steps during fetch
   a_r9_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
      (car == UA_FETCH + 7'd1) |=> (pc == $past(pc) + 1'b1));

   // R2: add microstep sums the operand
   a_r2_add_sum: assert property (@(posedge clk) disable iff (!rst_n)
      (car == UA_ADD_EXE) |=> (ac == $past(ac) + $past(dr)));

   // R5: swap is simultaneous
   a_r5_swap: assert property (@(posedge clk) disable iff (!rst_n)
      (car == UA_XCH_SWP) |=> (ac == $past(dr) && dr == $past(ac)));

   // R6: indirect subroutine returns to the caller
   a_r6_return: assert property (@(posedge clk) disable iff (!rst_n)
      (car == UA_IND_RET) |=> (car == $past(sbr)));

   // R8: a write strobe lasts one cycle
   a_r8_single_write: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> !mem_we);

endmodule

bind upc_core upc_core_sva #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_sva (
   .clk    (clk),
   .rst_n  (rst_n),
   .car    (car_q),
   .sbr    (sbr_q),
   .pc     (pc_q),
   .ac     (ac_q),
   .dr     (dr_q),
   .mem_we (mem_we)
);

// File: tb/upc_core_bench.sv
module upc_core_bench;

   localparam int DW     = 16;
   localparam int AW     = 11;
   localparam int MWORDS = 1 << AW;
   localparam int RUN_CY = 400;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic          mem_we;
   logic [DW-1:0] mem_rdata;
   logic [DW-1:0] acc_o;
   logic [AW-1:0] pc_o;
   logic          fetch_o;

   logic [DW-1:0] dmem [MWORDS];
   logic [DW-1:0] rmem [MWORDS];

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [DW-1:0] m_acc = '0;
   logic [AW-1:0] m_pc  = '0;
   int            m_writes = 0;
   int            seen_writes = 0;
   string         m_tag = "R1";
   string         m_pc_tag = "R9";

   always #5ns clk = ~clk;

   upc_core u_upc_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_we    (mem_we),
      .mem_rdata (mem_rdata),
      .acc_o     (acc_o),
      .pc_o      (pc_o),
      .fetch_o   (fetch_o)
   );

   assign mem_rdata = dmem[mem_addr];

   always @(posedge clk) if (mem_we) dmem[mem_addr] <= mem_wdata;

   task automatic check(input string req, input string what,
                        input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
      end
   endtask

   function automatic logic [DW-1:0] ins(input bit ind, input int opc, input int adr);
      return {ind, 4'(opc), 11'(adr)};
   endfunction

   // behavioural instruction model; returns instruction length in cycles
   task automatic model_exec(output int len);
      logic [DW-1:0] iw;
      logic [AW-1:0] ea;
      logic [DW-1:0] tmp;
      int            extra;
      iw = rmem[m_pc];
      m_pc = m_pc + 1'b1;
      ea = iw[10:0];
      extra = 0;
      if (iw[15]) begin
         ea = rmem[ea][10:0];
         extra = 2;
      end
      m_pc_tag = "R9";
      case (iw[14:11])
         4'd0: begin m_acc = m_acc + rmem[ea]; len = 6 + extra; m_tag = "R2"; end
         4'd1: begin
            m_tag = "R3"; m_pc_tag = "R3";
            if (m_acc[15]) begin m_pc = ea; len = 6 + extra; end
            else len = 5;
         end
         4'd2: begin rmem[ea] = m_acc; len = 6 + extra; m_writes++; m_tag = "R4"; end
         4'd3: begin
            tmp = rmem[ea]; rmem[ea] = m_acc; m_acc = tmp;
            len = 7 + extra; m_writes++; m_tag = "R5";
         end
         default: begin len = 4; m_tag = "R7"; end
      endcase
   endtask

   initial begin
      #2ms;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int rem;
      int len;
      for (int i = 0; i < MWORDS; i++) dmem[i] = '0;
      dmem[0]   = ins(0, 0, 100);  // add 100
      dmem[1]   = ins(1, 0, 104);  // add indirect -> 102
      dmem[2]   = ins(0, 2, 103);  // store 103
      dmem[3]   = ins(0, 1, 20);   // branch, not taken
      dmem[4]   = ins(0, 3, 105);  // exchange 105
      dmem[5]   = ins(1, 3, 106);  // exchange indirect -> 105
      dmem[6]   = ins(0, 0, 101);  // add -16
      dmem[7]   = ins(1, 2, 107);  // store indirect -> 103
      dmem[8]   = ins(1, 1, 108);  // branch indirect -> 10, taken
      dmem[9]   = ins(0, 0, 100);  // skipped
      dmem[10]  = ins(0, 1, 10);   // self-loop
      dmem[100] = 16'd5;
      dmem[101] = 16'hFFF0;
      dmem[102] = 16'd7;
      dmem[104] = 16'd102;
      dmem[105] = 16'h1234;
      dmem[106] = 16'h8000 | 16'd105;
      dmem[107] = 16'd103;
      dmem[108] = 16'd10;
      for (int i = 0; i < MWORDS; i++) rmem[i] = dmem[i];

      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1", "reset acc", acc_o, 0);
      check("R1", "reset pc", pc_o, 0);
      check("R1", "reset fetch", fetch_o, 1);
      check("R1", "reset we", mem_we, 0);
      rst_n = 1'b1;

      rem = 0;
      for (int c = 0; c < RUN_CY; c++) begin
         if (mem_we) seen_writes++;
         if (rem == 0) begin
            check("R7", "fetch pulse at start", fetch_o, 1);
            check(m_tag, "acc at boundary", acc_o, m_acc);
            check(m_pc_tag, "pc at boundary", pc_o, m_pc);
            model_exec(len);
            rem = len;
         end else begin
            check("R7", "no fetch mid-instruction", fetch_o, 0);
         end
         rem--;
         @(negedge clk);
      end

      check("R8", "write count", seen_writes, m_writes);
      check("R4", "stored word 103", dmem[103], 16'hFFFC);
      check("R6", "indirect store matches model", dmem[103], rmem[103]);
      check("R5", "exchanged word 105", dmem[105], 16'h1234);
      check("R2", "final acc", acc_o, 16'hFFFC);
      for (int i = 0; i < 128; i++) begin
         if (dmem[i] !== rmem[i]) check("R4", "memory image", dmem[i], rmem[i]);
      end
      check("R3", "model ended in self-loop", (m_pc == 11'd10 || m_pc == 11'd11), 1);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule